// File: doc/BRIEF.md
# Floating-Point Register Specifier Decoder

This block turns the 5-bit register fields of a floating-point instruction word into 6-bit physical register numbers. Each of the three operands (first source, second source, destination) comes with a 2-bit size code chosen by the opcode decoder upstream. Single-precision fields name registers 0 to 31 directly. Double- and quad-precision fields fold their low bit into the top bit of the index, so they can reach the upper half of a 64-entry file.

The block also keeps a lazy-save context of three bits: an FP-enable flag and one "dirty" bit for each half of the file. A source operand in a clean half is flagged as reading zero. The first write into a clean half is preceded by a one-cycle request to clear that whole half. If the enable flag is clear when a write arrives, the context is reset to enable-only and a one-cycle request to clear the graphics status register is raised.

Before any of this, the trap-type value that came with the request must match the value expected for the opcode. If it does not, the request is rejected. A quad operand whose field has bit 1 set is illegal and yields trap code 6.

Top module: `fpr_spec_decoder`

## Requirements
- R1: The operand fields are taken from instr[18:14] (first source), instr[4:0] (second source) and instr[29:25] (destination). With size code 1 (single), the physical index is {1'b0, field}.
- R2: With size code 2 (double) or 3 (quad), the physical index is {field[0], field[4:1], 1'b0}. With size code 0 (none), the index reads 0 and the operand's zero flag reads 0.
- R3: When the trap type matches and any quad operand has field bit 1 set, the result shows ill_reg=1 and res_tt=6. No clear and no write follow, and the context is unchanged.
- R4: When req_tt differs from exp_tt, the result shows tt_reject=1, ill_reg=0 and res_tt=req_tt. No clear and no write follow, and the context is unchanged.
- R5: When a request is neither rejected nor illegal, res_tt reads 0.
- R6: A source operand reads as zero when the half of the file its index falls in is not dirty. Indices below 32 are in the lower half and the rest are in the upper half. The dirty state used is the one that holds when the request is accepted.
- R7: A destination write into a clean half is signalled as follows. The result appears one cycle after acceptance. In the next cycle a single-cycle clr_pulse appears, with clr_upper naming the half. The cycle after that, wr_en carries wr_idx. Afterwards the half reads dirty and fp_en reads 1.
- R8: A destination write into a dirty half, with fp_en set, raises wr_en in the cycle right after the result, with no clr_pulse.
- R9: When fp_en is clear at a destination write, gsr_clr rises together with clr_pulse. Afterwards fp_en=1, only the written half is dirty, and the other half's dirty bit is cleared.
- R10: With destination size 0, no clr_pulse and no wr_en follow, and the context is unchanged.
- R11: After reset, ready=1, fp_en=0, dirty_lo=0, dirty_hi=0, and res_valid, clr_pulse and wr_en are 0.
- R12: A ctx_load while ready loads {fp_en, dirty_hi, dirty_lo} from ctx_in[2:0], and a request in that same cycle is not accepted. A request is accepted only while ready=1, and ready stays 0 until the sequence for that request ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken while ready=1 |
| instr | input | 32 | Instruction word holding the three register fields |
| sz_rs1 | input | 2 | First source size code (0 none, 1 single, 2 double, 3 quad) |
| sz_rs2 | input | 2 | Second source size code |
| sz_rd | input | 2 | Destination size code |
| req_tt | input | 3 | Trap type carried by the request |
| exp_tt | input | 3 | Trap type expected for the opcode |
| ctx_load | input | 1 | Load the context from ctx_in |
| ctx_in | input | 3 | Context to load as {fp_en, dirty_hi, dirty_lo} |
| ready | output | 1 | Idle and able to accept a request |
| res_valid | output | 1 | Decode result valid for one cycle |
| rs1_idx | output | 6 | First source physical index |
| rs2_idx | output | 6 | Second source physical index |
| rd_idx | output | 6 | Destination physical index |
| rs1_zero | output | 1 | First source reads as zero |
| rs2_zero | output | 1 | Second source reads as zero |
| ill_reg | output | 1 | Illegal quad register specifier |
| tt_reject | output | 1 | Trap type mismatch |
| res_tt | output | 3 | Resulting trap-type field |
| clr_pulse | output | 1 | Request to clear one half of the file |
| clr_upper | output | 1 | Half to clear: 1 upper, 0 lower |
| gsr_clr | output | 1 | Request to clear the graphics status register |
| wr_en | output | 1 | Destination write enable |
| wr_idx | output | 6 | Destination write index |
| fp_en | output | 1 | FP-enable flag |
| dirty_lo | output | 1 | Lower half dirty |
| dirty_hi | output | 1 | Upper half dirty |

## Verification
The hardest situation to reach is a write that arrives while the enable flag is clear but both halves are already marked dirty. The decode must then report both sources as non-zero, and the write must still raise the graphics clear, clear one half, and drop the dirty bit of the other half. Reset alone never produces that context, so the stimulus first loads it through ctx_load and then issues a double-precision write into the upper half. The other context patterns, enabled with one half clean, are also reached through ctx_load, so that both the clear-then-write path and the direct-write path can be exercised for each half.

// File: rtl/fpr_pkg.sv
`timescale 1ns/1ps
package fpr_pkg;
  localparam int FLD_W      = 5;
  localparam int IDX_W      = FLD_W + 1;
  localparam int TT_W       = 3;
  localparam int NUM_OPS    = 3;
  localparam int OP_RS1     = 0;
  localparam int OP_RS2     = 1;
  localparam int OP_RD      = 2;
  localparam int CTX_W      = 3;
  localparam logic [TT_W-1:0] TT_ILLEGAL = TT_W'(6);

  typedef enum logic [1:0] {SZ_NONE = 2'd0, SZ_SINGLE = 2'd1,
                            SZ_DOUBLE = 2'd2, SZ_QUAD = 2'd3} opsize_e;

  typedef enum logic [1:0] {S_IDLE, S_RES, S_CLR, S_WR} seq_e;

  // bit position of the low end of each operand field
  function automatic int fld_lsb(int op);
    case (op)
      OP_RS1:  return 14;
      OP_RS2:  return 0;
      default: return 25;
    endcase
  endfunction
endpackage

// File: rtl/fpr_field_map.sv
`timescale 1ns/1ps
module fpr_field_map
  import fpr_pkg::*;
#(
  parameter int FW = FLD_W,
  parameter int IW = FW + 1
) (
  input  logic [FW-1:0] field,
  input  logic [1:0]    size,
  output logic [IW-1:0] idx,
  output logic          present,
  output logic          upper,
  output logic          illegal
);
  always_comb begin
    idx = '0;
    case (opsize_e'(size))
      SZ_SINGLE:          idx = IW'(field);
      SZ_DOUBLE, SZ_QUAD: idx = {field[0], field[FW-1:1], 1'b0};
      default:            idx = '0;
    endcase
  end

  assign present = (size != SZ_NONE);
  assign upper   = idx[IW-1];
  assign illegal = (size == SZ_QUAD) && field[1];
endmodule

// File: rtl/fpr_seq.sv
`timescale 1ns/1ps
module fpr_seq
  import fpr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic             ctx_load,
  input  logic [CTX_W-1:0] ctx_in,
  input  logic             abort,
  input  logic             rd_present,
  input  logic             rd_upper,
  output logic             ready,
  output logic             res_valid,
  output logic             clr_pulse,
  output logic             clr_upper,
  output logic             gsr_clr,
  output logic             wr_en,
  output logic             fp_en,
  output logic             dirty_lo,
  output logic             dirty_hi
);
  seq_e st_q, st_d;
  logic fen_q, fen_d, dlo_q, dlo_d, dhi_q, dhi_d;
  logic pwr_q, pwr_d, pclr_q, pclr_d, pgsr_q, pgsr_d, pup_q, pup_d;

  always_comb begin
    st_d   = st_q;
    fen_d  = fen_q;
    dlo_d  = dlo_q;
    dhi_d  = dhi_q;
    pwr_d  = pwr_q;
    pclr_d = pclr_q;
    pgsr_d = pgsr_q;
    pup_d  = pup_q;
    case (st_q)
      S_IDLE: begin
        if (ctx_load) begin
          {fen_d, dhi_d, dlo_d} = ctx_in;
        end else if (accept) begin
          pwr_d  = !abort && rd_present;
          pup_d  = rd_upper;
          pgsr_d = !fen_q;
          pclr_d = !fen_q || !(rd_upper ? dhi_q : dlo_q);
          st_d   = S_RES;
        end
      end
      S_RES: st_d = pwr_q ? (pclr_q ? S_CLR : S_WR) : S_IDLE;
      S_CLR: st_d = S_WR;
      S_WR: begin
        fen_d = 1'b1;
        if (pgsr_q) begin
          dhi_d = pup_q;
          dlo_d = !pup_q;
        end else if (pup_q) begin
          dhi_d = 1'b1;
        end else begin
          dlo_d = 1'b1;
        end
        st_d = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      fen_q  <= 1'b0;
      dlo_q  <= 1'b0;
      dhi_q  <= 1'b0;
      pwr_q  <= 1'b0;
      pclr_q <= 1'b0;
      pgsr_q <= 1'b0;
      pup_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      fen_q  <= fen_d;
      dlo_q  <= dlo_d;
      dhi_q  <= dhi_d;
      pwr_q  <= pwr_d;
      pclr_q <= pclr_d;
      pgsr_q <= pgsr_d;
      pup_q  <= pup_d;
    end
  end

  assign ready     = (st_q == S_IDLE);
  assign res_valid = (st_q == S_RES);
  assign clr_pulse = (st_q == S_CLR);
  assign clr_upper = clr_pulse && pup_q;
  assign gsr_clr   = clr_pulse && pgsr_q;
  assign wr_en     = (st_q == S_WR);
  assign fp_en     = fen_q;
  assign dirty_lo  = dlo_q;
  assign dirty_hi  = dhi_q;
endmodule

// File: rtl/fpr_spec_decoder.sv
`timescale 1ns/1ps
module fpr_spec_decoder
  import fpr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [31:0]       instr,
  input  logic [1:0]        sz_rs1,
  input  logic [1:0]        sz_rs2,
  input  logic [1:0]        sz_rd,
  input  logic [TT_W-1:0]   req_tt,
  input  logic [TT_W-1:0]   exp_tt,
  input  logic              ctx_load,
  input  logic [CTX_W-1:0]  ctx_in,
  output logic              ready,
  output logic              res_valid,
  output logic [IDX_W-1:0]  rs1_idx,
  output logic [IDX_W-1:0]  rs2_idx,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              rs1_zero,
  output logic              rs2_zero,
  output logic              ill_reg,
  output logic              tt_reject,
  output logic [TT_W-1:0]   res_tt,
  output logic              clr_pulse,
  output logic              clr_upper,
  output logic              gsr_clr,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic              fp_en,
  output logic              dirty_lo,
  output logic              dirty_hi
);
  logic [1:0]       sz      [NUM_OPS];
  logic [IDX_W-1:0] map_idx [NUM_OPS];
  logic [NUM_OPS-1:0] map_pres, map_up, map_ill;

  assign sz[OP_RS1] = sz_rs1;
  assign sz[OP_RS2] = sz_rs2;
  assign sz[OP_RD]  = sz_rd;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    localparam int LSB = fld_lsb(g);
    fpr_field_map #(.FW(FLD_W), .IW(IDX_W)) u_map (
      .field   (instr[LSB +: FLD_W]),
      .size    (sz[g]),
      .idx     (map_idx[g]),
      .present (map_pres[g]),
      .upper   (map_up[g]),
      .illegal (map_ill[g])
    );
  end

  logic accept, mismatch, bad_reg, abort;
  assign accept   = ready && req_valid && !ctx_load;
  assign mismatch = (req_tt != exp_tt);
  assign bad_reg  = |map_ill;
  assign abort    = mismatch || bad_reg;

  // decode result registers
  logic [IDX_W-1:0] idx1_d, idx2_d, idxd_d, idx1_q, idx2_q, idxd_q;
  logic z1_d, z2_d, ill_d, rej_d, z1_q, z2_q, ill_q, rej_q;
  logic [TT_W-1:0] tt_d, tt_q;

  always_comb begin
    idx1_d = map_idx[OP_RS1];
    idx2_d = map_idx[OP_RS2];
    idxd_d = map_idx[OP_RD];
    z1_d   = map_pres[OP_RS1] && !(map_up[OP_RS1] ? dirty_hi : dirty_lo);
    z2_d   = map_pres[OP_RS2] && !(map_up[OP_RS2] ? dirty_hi : dirty_lo);
    rej_d  = mismatch;
    ill_d  = bad_reg && !mismatch;
    if (mismatch)     tt_d = req_tt;
    else if (bad_reg) tt_d = TT_ILLEGAL;
    else              tt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx1_q <= '0;
      idx2_q <= '0;
      idxd_q <= '0;
      z1_q   <= 1'b0;
      z2_q   <= 1'b0;
      ill_q  <= 1'b0;
      rej_q  <= 1'b0;
      tt_q   <= '0;
    end else if (accept) begin
      idx1_q <= idx1_d;
      idx2_q <= idx2_d;
      idxd_q <= idxd_d;
      z1_q   <= z1_d;
      z2_q   <= z2_d;
      ill_q  <= ill_d;
      rej_q  <= rej_d;
      tt_q   <= tt_d;
    end
  end

  fpr_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept),
    .ctx_load   (ctx_load),
    .ctx_in     (ctx_in),
    .abort      (abort),
    .rd_present (map_pres[OP_RD]),
    .rd_upper   (map_up[OP_RD]),
    .ready      (ready),
    .res_valid  (res_valid),
    .clr_pulse  (clr_pulse),
    .clr_upper  (clr_upper),
    .gsr_clr    (gsr_clr),
    .wr_en      (wr_en),
    .fp_en      (fp_en),
    .dirty_lo   (dirty_lo),
    .dirty_hi   (dirty_hi)
  );

  assign rs1_idx   = idx1_q;
  assign rs2_idx   = idx2_q;
  assign rd_idx    = idxd_q;
  assign rs1_zero  = z1_q;
  assign rs2_zero  = z2_q;
  assign ill_reg   = ill_q;
  assign tt_reject = rej_q;
  assign res_tt    = tt_q;
  assign wr_idx    = idxd_q;
endmodule

// File: rtl/fpr_spec_decoder_chk.sv
`timescale 1ns/1ps
module fpr_spec_decoder_chk
  import fpr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             ready,
  input logic             res_valid,
  input logic             ill_reg,
  input logic             tt_reject,
  input logic [TT_W-1:0]  res_tt,
  input logic             clr_pulse,
  input logic             gsr_clr,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic             fp_en,
  input logic             dirty_lo,
  input logic             dirty_hi
);
  a_r7_clear_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> wr_en);
  a_r7_clear_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pulse |=> !clr_pulse);
  a_r7_lower_dirty_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_idx[IDX_W-1]) |=> (dirty_lo && fp_en));
  a_r7_upper_dirty_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx[IDX_W-1]) |=> (dirty_hi && fp_en));
  a_r3_illegal_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && ill_reg) |=> (!clr_pulse && !wr_en));
  a_r3_illegal_code: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && ill_reg) |-> (res_tt == TT_ILLEGAL));
  a_r4_reject_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && tt_reject) |=> (!clr_pulse && !wr_en));
  a_r9_gsr_with_clear: assert property (@(posedge clk) disable iff (!rst_n)
    gsr_clr |-> (clr_pulse && !fp_en));
  a_r12_phases_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ready, res_valid, clr_pulse, wr_en}));
endmodule

bind fpr_spec_decoder fpr_spec_decoder_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ready     (ready),
  .res_valid (res_valid),
  .ill_reg   (ill_reg),
  .tt_reject (tt_reject),
  .res_tt    (res_tt),
  .clr_pulse (clr_pulse),
  .gsr_clr   (gsr_clr),
  .wr_en     (wr_en),
  .wr_idx    (wr_idx),
  .fp_en     (fp_en),
  .dirty_lo  (dirty_lo),
  .dirty_hi  (dirty_hi)
);

// File: tb/tb_fpr_spec_decoder.sv
`timescale 1ns/1ps
module tb_fpr_spec_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [31:0] instr = '0;
  logic [1:0] sz_rs1 = '0, sz_rs2 = '0, sz_rd = '0;
  logic [2:0] req_tt = '0, exp_tt = '0;
  logic ctx_load = 1'b0;
  logic [2:0] ctx_in = '0;
  logic ready, res_valid, rs1_zero, rs2_zero, ill_reg, tt_reject;
  logic clr_pulse, clr_upper, gsr_clr, wr_en, fp_en, dirty_lo, dirty_hi;
  logic [5:0] rs1_idx, rs2_idx, rd_idx, wr_idx;
  logic [2:0] res_tt;

  always #2.5 clk = ~clk;

  fpr_spec_decoder dut (.*);

  typedef struct packed {
    logic [5:0] i1, i2, id;
    logic z1, z2, ill, rej;
    logic [2:0] tt;
    logic clr, cup, gsr, wr;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_fail = 0;
  logic m_fen = 0, m_dlo = 0, m_dhi = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic logic [5:0] map(input logic [4:0] f, input logic [1:0] s);
    if (s == 2'd1) return {1'b0, f};
    if (s >= 2'd2) return {f[0], f[4:1], 1'b0};
    return 6'd0;
  endfunction

  task automatic check_ctx(input string req);
    chk({fp_en, dirty_hi, dirty_lo} == {m_fen, m_dhi, m_dlo}, req,
        {fp_en, dirty_hi, dirty_lo}, {m_fen, m_dhi, m_dlo});
  endtask

  task automatic load_ctx(input logic [2:0] v);
    ctx_load = 1'b1; ctx_in = v;
    @(negedge clk);
    ctx_load = 1'b0;
    {m_fen, m_dhi, m_dlo} = v;
    check_ctx("R12 ctx load");
  endtask

  // driver: computes expectation from the requirements and pushes it
  task automatic run(input logic [4:0] f1, f2, fd, input logic [1:0] s1, s2, sd,
                     input logic [2:0] rtt, ett);
    exp_t e;
    logic [5:0] id;
    logic bad, up;
    bad = (s1 == 2'd3 && f1[1]) || (s2 == 2'd3 && f2[1]) || (sd == 2'd3 && fd[1]);
    e.i1 = map(f1, s1); e.i2 = map(f2, s2); id = map(fd, sd); e.id = id;
    e.z1 = (s1 != 0) && !(e.i1[5] ? m_dhi : m_dlo);
    e.z2 = (s2 != 0) && !(e.i2[5] ? m_dhi : m_dlo);
    e.rej = (rtt != ett);
    e.ill = bad && !e.rej;
    e.tt = e.rej ? rtt : (bad ? 3'd6 : 3'd0);
    e.wr = !e.rej && !bad && (sd != 0);
    up = id[5];
    e.clr = e.wr && (!m_fen || !(up ? m_dhi : m_dlo));
    e.cup = e.clr && up;
    e.gsr = e.wr && !m_fen;
    q.push_back(e);
    instr = {2'b00, fd, 6'b0, f1, 9'b0, f2};
    sz_rs1 = s1; sz_rs2 = s2; sz_rd = sd; req_tt = rtt; exp_tt = ett;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (e.wr) begin
      if (!m_fen) begin m_dhi = up; m_dlo = !up; end
      else if (up) m_dhi = 1'b1;
      else m_dlo = 1'b1;
      m_fen = 1'b1;
    end
    do @(negedge clk); while (!ready);
    check_ctx("R9 R10 context after request");
  endtask

  // monitor: pops expectations as results appear
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      if (rst_n && res_valid) begin
        if (q.size() == 0) begin
          chk(0, "R12 unexpected result", 1, 0);
        end else begin
          e = q.pop_front();
          chk(rs1_idx == e.i1, "R1 R2 rs1 index", rs1_idx, e.i1);
          chk(rs2_idx == e.i2, "R1 R2 rs2 index", rs2_idx, e.i2);
          chk(rd_idx == e.id, "R1 R2 rd index", rd_idx, e.id);
          chk({rs1_zero, rs2_zero} == {e.z1, e.z2}, "R6 zero flags",
              {rs1_zero, rs2_zero}, {e.z1, e.z2});
          chk(ill_reg == e.ill, "R3 ill_reg", ill_reg, e.ill);
          chk(tt_reject == e.rej, "R4 tt_reject", tt_reject, e.rej);
          chk(res_tt == e.tt, "R5 res_tt", res_tt, e.tt);
          @(negedge clk);
          if (e.clr) begin
            chk(clr_pulse && !wr_en, "R7 clear pulse", {clr_pulse, wr_en}, 2'b10);
            chk(clr_upper == e.cup, "R7 clear half", clr_upper, e.cup);
            chk(gsr_clr == e.gsr, "R9 gsr clear", gsr_clr, e.gsr);
            @(negedge clk);
            chk(wr_en && !clr_pulse, "R7 write after clear", {clr_pulse, wr_en}, 2'b01);
            chk(wr_idx == e.id, "R7 write index", wr_idx, e.id);
          end else if (e.wr) begin
            chk(wr_en && !clr_pulse, "R8 direct write", {clr_pulse, wr_en}, 2'b01);
            chk(wr_idx == e.id, "R8 write index", wr_idx, e.id);
          end else begin
            chk(!wr_en && !clr_pulse, "R10 no write", {clr_pulse, wr_en}, 2'b00);
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready && !res_valid && !clr_pulse && !wr_en, "R11 reset outputs",
        {ready, res_valid, clr_pulse, wr_en}, 4'b1000);
    check_ctx("R11 reset context");
    // single write into clean lower half with enable clear
    run(5'd3, 5'd31, 5'd5, 2'd1, 2'd1, 2'd1, 3'd2, 3'd2);
    // double write into clean upper half
    run(5'd7, 5'd4, 5'd3, 2'd2, 2'd2, 2'd2, 3'd2, 3'd2);
    // quad write into dirty upper half
    run(5'd17, 5'd12, 5'd17, 2'd3, 2'd3, 2'd3, 3'd3, 3'd3);
    // illegal quad source and illegal quad destination
    run(5'd0, 5'd2, 5'd0, 2'd3, 2'd3, 2'd3, 3'd3, 3'd3);
    run(5'd0, 5'd0, 5'd6, 2'd3, 2'd3, 2'd3, 3'd3, 3'd3);
    // trap type mismatch, also with an illegal field
    run(5'd1, 5'd2, 5'd4, 2'd1, 2'd3, 2'd1, 3'd2, 3'd3);
    // no operands at all
    run(5'd9, 5'd9, 5'd9, 2'd0, 2'd0, 2'd0, 3'd0, 3'd0);
    // enable clear with both halves dirty, write to upper
    load_ctx(3'b011);
    run(5'd9, 5'd1, 5'd1, 2'd1, 2'd2, 2'd2, 3'd2, 3'd2);
    // enabled, lower clean: clear then write lower
    load_ctx(3'b110);
    run(5'd2, 5'd30, 5'd2, 2'd2, 2'd1, 2'd2, 3'd2, 3'd2);
    // request together with ctx_load is not accepted
    ctx_load = 1'b1; ctx_in = 3'b101; req_valid = 1'b1;
    instr = '0; sz_rd = 2'd1; req_tt = '0; exp_tt = '0;
    @(negedge clk);
    ctx_load = 1'b0; req_valid = 1'b0;
    {m_fen, m_dhi, m_dlo} = 3'b101;
    chk(ready && !res_valid, "R12 request ignored on ctx load", {ready, res_valid}, 2'b10);
    check_ctx("R12 ctx load with request");
    // enabled, upper clean: clear upper, lower stays
    run(5'd0, 5'd0, 5'd21, 2'd2, 2'd2, 2'd2, 3'd1, 3'd1);
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R12 all results seen", q.size(), 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule